// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns pin activity on a microcontroller's general-purpose ports into interrupt requests and a wakeup event. It serves sixteen lines. Line n can watch pin n of any one of nine 16-bit ports, and a 4-bit port code held for that line picks the port. The chosen pin passes through a two-flop synchronizer. A change of the synchronized value from one cycle to the next counts as an edge, and the rising and falling enable bits of the line decide whether that edge is accepted.

An accepted edge latches a pending flag for the line. The flag stays set until software writes a 1 to its bit. Pending flags are gated by an interrupt mask and drive seven IRQ outputs. Lines 0 to 4 each have their own output. Lines 5 to 9 share one output and lines 10 to 15 share another. A separate event mask turns accepted edges into a one-cycle wakeup pulse, ORed over all lines.

Each line has a small state machine with two states. `LN_IDLE` means nothing is pending and `LN_PEND` means the line is latched. Transition LATCH (`LN_IDLE` to `LN_PEND`) fires on an accepted edge. Transition ACK (`LN_PEND` to `LN_IDLE`) fires on a write-1 clear in a cycle with no accepted edge on that line. In every other case the line holds its state. Software reaches the configuration through a simple register bus: a write strobe, an address, write data and combinational read data.

Top module: `exti_ctrl`

## Requirements
- R1: After reset every register reads 0: the port selects, both masks, both trigger enables and the pending flags. `irq_out` is 0 and `wake_evt` is 0.
- R2: The port-select registers sit at addresses 0 to 3. Address k holds lines 4k to 4k+3, and line n uses bits [4*(n mod 4)+3 : 4*(n mod 4)]. A code c from 0 to 8 makes line n watch `port_pins[16*c+n]`, and pins of other ports have no effect on that line. Written values read back unchanged.
- R3: A port code from 9 to 15 feeds the line a constant high, so once the selection has settled no pin activity sets its pending flag.
- R4: Address 6 holds the rising enables and address 7 holds the falling enables, one bit per line. A pin change driven between clock edges sets the pending flag after the third following rising clock edge, and not after the second. With both enables set the line accepts both edges. With neither set it accepts none.
- R5: Address 8 reads the pending flags. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged.
- R6: When a clear of a line and an accepted edge on the same line fall in the same cycle, the flag stays set.
- R7: For n from 0 to 4, `irq_out[n]` is high when line n is pending and unmasked. `irq_out[5]` is the OR of lines 5 to 9 and `irq_out[6]` is the OR of lines 10 to 15. An output stays high as long as its pending flag does.
- R8: Address 5 holds the event mask. An accepted edge on an event-enabled line gives `wake_evt` high for exactly one cycle, in the same cycle the pending flag first shows. With the event bit clear there is no pulse, but the flag is still latched.
- R9: Address 4 holds the interrupt mask. A pending line whose mask bit is clear raises no IRQ. Setting the mask bit later raises the IRQ at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | 144 | Nine 16-bit ports; port c occupies bits 16c+15 to 16c |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (0 for unused addresses) |
| irq_out | output | 7 | Grouped interrupt requests |
| wake_evt | output | 1 | One-cycle wakeup pulse |

## Verification
The bench aims at five corner cases.

- **Collision of a clear and a new edge.** The bench places a write-1 clear in exactly the cycle a new edge is accepted. A design that lets the clear win would drop that interrupt.
- **Edge latency.** The bench checks the flag on both sides of its third clock edge. A missing or extra synchronizer stage moves the flag by one cycle.
- **Constant-high port codes and switching between ports.** These check that the mux neither leaks foreign pins nor loses the edge that a select change causes.
- **Shared IRQ groups.** Two lines pending in different groups must both be visible, and each output must drop only with its own line. A wrong boundary between groups would light the wrong output.
- **Random traffic.** A long random run of pins and writes is compared every clock against a behavioural model. It catches any cycle in which the pending flags, the IRQs, the wakeup pulse or the read data differ from the model.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int EX_LINES      = 16;  // lines, also pins per port
    localparam int EX_PORTS      = 9;   // selectable ports
    localparam int EX_SEL_W      = 4;   // port code width
    localparam int EX_ADDR_W     = 4;
    localparam int EX_DATA_W     = 16;
    localparam int EX_SOLO_LINES = 5;   // lines with a private IRQ
    localparam int EX_MID_LAST   = 9;   // last line of the first shared group
    localparam int EX_NUM_IRQ    = EX_SOLO_LINES + 2;

    typedef enum logic [EX_ADDR_W-1:0] {
        A_SEL0  = 4'd0,
        A_SEL1  = 4'd1,
        A_SEL2  = 4'd2,
        A_SEL3  = 4'd3,
        A_IMASK = 4'd4,
        A_EMASK = 4'd5,
        A_RISE  = 4'd6,
        A_FALL  = 4'd7,
        A_PEND  = 4'd8
    } reg_addr_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;

    // IRQ output that a line feeds
    function automatic int irq_slot(input int line);
        if (line < EX_SOLO_LINES)
            return line;
        else if (line <= EX_MID_LAST)
            return EX_SOLO_LINES;
        else
            return EX_SOLO_LINES + 1;
    endfunction

    // Set of lines ORed onto one IRQ output
    function automatic logic [EX_LINES-1:0] group_mask(input int slot);
        logic [EX_LINES-1:0] m;
        m = '0;
        for (int n = 0; n < EX_LINES; n++)
            if (irq_slot(n) == slot)
                m[n] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int LINES  = EX_LINES,
    parameter int SEL_W  = EX_SEL_W,
    parameter int ADDR_W = EX_ADDR_W,
    parameter int DATA_W = EX_DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [LINES-1:0]       pend_i,
    output logic [LINES*SEL_W-1:0] sel_o,
    output logic [LINES-1:0]       imask_o,
    output logic [LINES-1:0]       emask_o,
    output logic [LINES-1:0]       rise_o,
    output logic [LINES-1:0]       fall_o,
    output logic [LINES-1:0]       clr_o,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int SEL_PER_REG = DATA_W / SEL_W;
    localparam int SEL_REGS    = LINES / SEL_PER_REG;

    logic [SEL_REGS-1:0][DATA_W-1:0] sel_q;
    logic [LINES-1:0] imask_q, emask_q, rise_q, fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            imask_q <= '0;
            emask_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else if (we_i) begin
            for (int k = 0; k < SEL_REGS; k++)
                if (addr_i == ADDR_W'(k))
                    sel_q[k] <= wdata_i;
            if (addr_i == A_IMASK) imask_q <= wdata_i[LINES-1:0];
            if (addr_i == A_EMASK) emask_q <= wdata_i[LINES-1:0];
            if (addr_i == A_RISE)  rise_q  <= wdata_i[LINES-1:0];
            if (addr_i == A_FALL)  fall_q  <= wdata_i[LINES-1:0];
        end
    end

    // Select registers laid end to end give line n at bits n*SEL_W
    assign sel_o   = sel_q;
    assign imask_o = imask_q;
    assign emask_o = emask_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
    assign clr_o   = (we_i && addr_i == A_PEND) ? wdata_i[LINES-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < SEL_REGS; k++)
            if (addr_i == ADDR_W'(k))
                rdata_o = sel_q[k];
        if (addr_i == A_IMASK) rdata_o = DATA_W'(imask_q);
        if (addr_i == A_EMASK) rdata_o = DATA_W'(emask_q);
        if (addr_i == A_RISE)  rdata_o = DATA_W'(rise_q);
        if (addr_i == A_FALL)  rdata_o = DATA_W'(fall_q);
        if (addr_i == A_PEND)  rdata_o = DATA_W'(pend_i);
    end

endmodule

// File: rtl/exti_line.sv
module exti_line
    import exti_pkg::*;
#(
    parameter int PORTS = EX_PORTS,
    parameter int SEL_W = EX_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] pins_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    input  logic             evt_en_i,
    input  logic             clr_i,
    output logic             pend_o,
    output logic             wake_hit_o
);

    localparam logic [SEL_W-1:0] FIRST_CONST = SEL_W'(PORTS);

    logic        mux_val, sync_a, sync_b, prev_b, hit;
    line_state_e state_q, state_d;

    // Port mux; codes past the last port give a constant high
    always_comb begin
        mux_val = 1'b1;
        for (int p = 0; p < PORTS; p++)
            if (sel_i == SEL_W'(p))
                mux_val = pins_i[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            sync_a <= mux_val;
            sync_b <= sync_a;
            prev_b <= sync_b;
        end
    end

    assign hit = (rise_en_i &  sync_b & ~prev_b) |
                 (fall_en_i & ~sync_b &  prev_b);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    // Next state: LATCH on an accepted edge, ACK on a clear without one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (hit)            state_d = LN_PEND;
            LN_PEND: if (clr_i && !hit)  state_d = LN_IDLE;
            default:                     state_d = LN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pend_o     = (state_q == LN_PEND);
        wake_hit_o = hit & evt_en_i;
    end

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_o) else $error("edge lost"); // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o) else $error("pending dropped"); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !hit) |=> !pend_o) else $error("pending without edge"); // R4
    AST_CONST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i >= FIRST_CONST && $past(sel_i) >= FIRST_CONST &&
         $past(sel_i, 2) >= FIRST_CONST && $past(sel_i, 3) >= FIRST_CONST) |-> !hit)
        else $error("edge on constant input"); // R3

endmodule

// File: rtl/exti_irq_map.sv
module exti_irq_map
    import exti_pkg::*;
#(
    parameter int LINES   = EX_LINES,
    parameter int NUM_IRQ = EX_NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   pend_i,
    input  logic [LINES-1:0]   imask_i,
    input  logic [LINES-1:0]   wake_hit_i,
    output logic [NUM_IRQ-1:0] irq_o,
    output logic               wake_o
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        localparam logic [LINES-1:0] GM = LINES'(group_mask(g));
        assign irq_o[g] = |(pend_i & imask_i & GM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_o <= 1'b0;
        else        wake_o <= |wake_hit_i;
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (|pend_i)) else $error("irq without pending"); // R7
    AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (|pend_i)) else $error("wake without pending"); // R8

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int LINES   = EX_LINES,
    parameter int PORTS   = EX_PORTS,
    parameter int SEL_W   = EX_SEL_W,
    parameter int ADDR_W  = EX_ADDR_W,
    parameter int DATA_W  = EX_DATA_W,
    parameter int NUM_IRQ = EX_NUM_IRQ
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS*LINES-1:0] port_pins,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [NUM_IRQ-1:0]     irq_out,
    output logic                   wake_evt
);

    logic [LINES*SEL_W-1:0] sel_flat;
    logic [LINES-1:0] imask, emask, rise_en, fall_en, clr, pend, wake_hit;

    exti_regs #(
        .LINES(LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .pend_i(pend), .sel_o(sel_flat),
        .imask_o(imask), .emask_o(emask), .rise_o(rise_en), .fall_o(fall_en),
        .clr_o(clr), .rdata_o(bus_rdata)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic [PORTS-1:0] line_pins;
        for (genvar p = 0; p < PORTS; p++) begin : g_pin
            assign line_pins[p] = port_pins[p*LINES + n];
        end
        exti_line #(.PORTS(PORTS), .SEL_W(SEL_W)) u_line (
            .clk(clk), .rst_n(rst_n), .pins_i(line_pins),
            .sel_i(sel_flat[n*SEL_W +: SEL_W]),
            .rise_en_i(rise_en[n]), .fall_en_i(fall_en[n]),
            .evt_en_i(emask[n]), .clr_i(clr[n]),
            .pend_o(pend[n]), .wake_hit_o(wake_hit[n])
        );
    end

    exti_irq_map #(.LINES(LINES), .NUM_IRQ(NUM_IRQ)) u_map (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .imask_i(imask),
        .wake_hit_i(wake_hit), .irq_o(irq_out), .wake_o(wake_evt)
    );

    AST_W1C_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND) |=>
        (($past(pend) & ~$past(bus_wdata[LINES-1:0]) & ~pend) == '0))
        else $error("zero write cleared a flag"); // R5
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == '0) |-> (irq_out == '0)) else $error("irq while all masked"); // R9

endmodule

// File: tb/exti_ctrl_test.sv
module exti_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [143:0] pins = '0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic [6:0]   irq_out;
    logic         wake_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exti_ctrl uut (
        .clk(clk), .rst_n(rst_n), .port_pins(pins), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .wake_evt(wake_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_sel;
    logic [15:0] m_im, m_em, m_ri, m_fa, m_pend;
    logic        m_wake;
    logic [15:0] hist[$];   // per-clock selected pin values, newest first

    function automatic logic [15:0] pick_pins();
        logic [15:0] v;
        for (int n = 0; n < 16; n++) begin
            int c;
            c = int'(m_sel[n*4 +: 4]);
            v[n] = (c < 9) ? pins[c*16 + n] : 1'b1;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = '0; m_im = '0; m_em = '0; m_ri = '0; m_fa = '0;
            m_pend = '0; m_wake = 1'b0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            logic [15:0] cur, old, trig, clrv, nv;
            cur  = hist[1];
            old  = hist[2];
            trig = (m_ri & cur & ~old) | (m_fa & ~cur & old);
            nv   = pick_pins();
            clrv = (bus_we && bus_addr == 4'd8) ? bus_wdata : 16'h0;
            m_pend = (m_pend & ~clrv) | trig;
            m_wake = |(trig & m_em);
            if (bus_we) begin
                if (bus_addr < 4'd4) m_sel[int'(bus_addr)*16 +: 16] = bus_wdata;
                if (bus_addr == 4'd4) m_im = bus_wdata;
                if (bus_addr == 4'd5) m_em = bus_wdata;
                if (bus_addr == 4'd6) m_ri = bus_wdata;
                if (bus_addr == 4'd7) m_fa = bus_wdata;
            end
            hist.push_front(nv);
            void'(hist.pop_back());
        end
    end

    function automatic logic [6:0] exp_irq();
        logic [6:0] r;
        r = '0;
        for (int n = 0; n < 16; n++) begin
            int s;
            s = (n < 5) ? n : ((n < 10) ? 5 : 6);
            if (m_pend[n] && m_im[n]) r[s] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [3:0] a);
        if (a < 4'd4) return m_sel[int'(a)*16 +: 16];
        case (a)
            4'd4: return m_im;
            4'd5: return m_em;
            4'd6: return m_ri;
            4'd7: return m_fa;
            4'd8: return m_pend;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(posedge clk) begin
        #(Q);
        chk("R7 R9 irq_out vs model", {25'h0, irq_out}, {25'h0, exp_irq()});
        chk("R8 wake_evt vs model", {31'h0, wake_evt}, {31'h0, m_wake});
        chk("R2 R5 bus_rdata vs model", {16'h0, bus_rdata}, {16'h0, exp_rd(bus_addr)});
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #(Q);
        chk(tag, {16'h0, bus_rdata}, {16'h0, e});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic at_sample();
        @(posedge clk);
        #(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 9; a++) rd_chk(4'(a), 16'h0, "R1 register reset value");
        at_sample();
        chk("R1 irq_out after reset", {25'h0, irq_out}, 32'h0);
        chk("R1 wake_evt after reset", {31'h0, wake_evt}, 32'h0);

        // R2: line 13 on port C (code 2 in nibble 1 of address 3)
        @(negedge clk); pins[2*16+13] = 1'b1;
        wr(4'd3, 16'h0020);
        wr(4'd7, 16'h2000);
        wr(4'd4, 16'h2000);
        wr(4'd5, 16'h2000);
        wait_cyc(5);
        rd_chk(4'd3, 16'h0020, "R2 select readback");
        @(negedge clk); pins[13] = 1'b1;
        wait_cyc(2);
        @(negedge clk); pins[13] = 1'b0;
        wait_cyc(5);
        rd_chk(4'd8, 16'h0000, "R2 foreign port ignored");

        // R4 latency, R8 pulse, R7 shared output
        @(negedge clk); bus_addr = 4'd8; pins[2*16+13] = 1'b0;
        @(posedge clk);
        at_sample();
        chk("R4 not pending after second edge", {31'h0, bus_rdata[13]}, 32'h0);
        at_sample();
        chk("R4 pending after third edge", {31'h0, bus_rdata[13]}, 32'h1);
        chk("R8 wake pulse with pending", {31'h0, wake_evt}, 32'h1);
        chk("R7 line 13 on shared upper irq", {25'h0, irq_out}, 32'h40);
        at_sample();
        chk("R8 wake lasts one cycle", {31'h0, wake_evt}, 32'h0);

        // R5: zero write keeps flag
        wr(4'd8, 16'h0000);
        rd_chk(4'd8, 16'h2000, "R5 zero write no effect");

        // R6: clear coincides with a new rising edge
        wr(4'd6, 16'h2000);
        @(negedge clk); bus_addr = 4'd8; pins[2*16+13] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wdata = 16'h2000; bus_we = 1'b1;
        at_sample();
        chk("R6 edge beats clear", {31'h0, bus_rdata[13]}, 32'h1);
        @(negedge clk); bus_we = 1'b0;
        wr(4'd8, 16'h2000);
        rd_chk(4'd8, 16'h0000, "R5 write one clears");
        chk("R7 irq drops with flag", {25'h0, irq_out}, 32'h0);

        // R8: event mask clear, edge still latched
        wr(4'd5, 16'h0000);
        @(negedge clk); pins[2*16+13] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            at_sample();
            chk("R8 no wake when event masked", {31'h0, wake_evt}, 32'h0);
        end
        rd_chk(4'd8, 16'h2000, "R8 flag latched without event");
        wr(4'd8, 16'h2000);

        // R9: pending line 2 without interrupt mask
        wr(4'd6, 16'h2004);
        @(negedge clk); pins[2] = 1'b1;
        wait_cyc(5);
        rd_chk(4'd8, 16'h0004, "R9 pending while masked");
        chk("R9 masked line raises no irq", {31'h0, irq_out[2]}, 32'h0);
        wr(4'd4, 16'h2004);
        at_sample();
        chk("R9 unmask raises irq", {25'h0, irq_out}, 32'h4);
        wr(4'd8, 16'h0004);
        at_sample();
        chk("R7 private irq drops", {25'h0, irq_out}, 32'h0);

        // R7: line 6 on port B, line 11 on port I
        wr(4'd1, 16'h0100);
        wr(4'd2, 16'h8000);
        wr(4'd6, 16'h2844);
        wr(4'd4, 16'h0840);
        @(negedge clk); pins[1*16+6] = 1'b1; pins[8*16+11] = 1'b1;
        wait_cyc(5);
        at_sample();
        chk("R7 both shared irqs", {25'h0, irq_out}, 32'h60);
        wr(4'd8, 16'h0040);
        at_sample();
        chk("R7 only upper group left", {25'h0, irq_out}, 32'h40);
        wr(4'd8, 16'h0800);
        at_sample();
        chk("R7 all groups idle", {25'h0, irq_out}, 32'h0);

        // R3: code 9 gives constant high
        wr(4'd0, 16'h0009);
        wr(4'd7, 16'h2001);
        wr(4'd6, 16'h2845);
        wait_cyc(5);
        wr(4'd8, 16'h0001);
        @(negedge clk); pins[0] = 1'b1; pins[16] = 1'b1;
        wait_cyc(3);
        @(negedge clk); pins[0] = 1'b0; pins[16] = 1'b0;
        wait_cyc(6);
        rd_chk(4'd8, 16'h0000, "R3 constant input never edges");
        rd_chk(4'd0, 16'h0009, "R2 code readback");

        // R4: no enables, then both edges
        @(negedge clk); pins[3] = 1'b1;
        wait_cyc(6);
        rd_chk(4'd8, 16'h0000, "R4 no enables no pending");
        wr(4'd7, 16'h2000);
        @(negedge clk); pins[2*16+13] = 1'b1;
        wait_cyc(5);
        rd_chk(4'd8, 16'h2000, "R4 both edges rising");
        wr(4'd8, 16'h2000);
        @(negedge clk); pins[2*16+13] = 1'b0;
        wait_cyc(5);
        rd_chk(4'd8, 16'h2000, "R4 both edges falling");
        wr(4'd8, 16'h2000);

        // Random traffic, compared every clock against the model
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            pins[$urandom % 144] = ~pins[$urandom % 144];
            pins[$urandom % 144] = $urandom % 2;
            bus_we    = (($urandom % 4) == 0);
            bus_addr  = 4'($urandom % 11);
            bus_wdata = 16'($urandom);
        end
        @(negedge clk); bus_we = 1'b0;
        wait_cyc(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule